// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block keeps a table of message-signalled interrupt vectors, with a parameterised count from 1 to 2048. Each vector has a 64-bit message address, a 32-bit message data word and a per-vector mask bit. A pending-bit array records vectors that fired while masked. Software reaches the table, the pending array and a small control register through a 32-bit register port. Device logic raises per-vector notify requests. The block turns each request into an address/data message write on a valid/ready output, or parks it as a pending bit.

Device logic also claims and releases vectors. Each vector has a use count, and a vector with a zero count never produces a message. A vector is effectively masked when its own mask bit is set or when the function is masked. The function is masked when the enable bit is clear or the mask-all bit is set. Whenever a vector moves from masked to unmasked with its pending bit set, the bit is cleared and a real message goes out. This holds whether the move comes from a write to that vector's control word or from a function-wide change, which starts a sweep over all vectors at one vector per clock. A control write made while enabled also produces a one-cycle pulse that tells the legacy wired interrupt logic to deassert.

Top module: `msix_ctrl`

## Requirements
- R1: After reset, enable and mask-all read as 0, every table address and data word reads 0, every vector control word reads 1 (masked), all pending bits read 0 and no message is offered.
- R2: A vector's table entry is 16 bytes at byte offset 16*v of the table space. Word 0 holds address bits 31:0, word 1 holds address bits 63:32, word 2 holds the data and word 3 holds the vector control word. Only bit 0 of the control word (the mask) is stored; its other bits read 0.
- R3: The control register has enable at bit 0, mask-all at bit 1 and a read-only size field at bits 26:16 that reads NUM_VEC-1. Writes to the size field have no effect.
- R4: A notify for a vector whose use count is zero is dropped. No message is sent and no pending bit is set.
- R5: A notify for a used vector that is effectively masked (function mask or its own mask bit) sets that vector's pending bit and sends no message.
- R6: A notify for a used vector that is not effectively masked sends one message carrying that entry's address and data.
- R7: A table write that clears a vector's mask bit while the function is unmasked and that vector is pending clears the pending bit and sends that vector's message. The same write on a non-pending vector sends nothing.
- R8: A control write that leaves the block enabled and changes the function mask from set to clear sweeps all vectors in ascending index order. Every pending vector whose own mask bit is clear is flushed as a message. Register writes and notifies are stalled until the sweep ends.
- R9: Writes to the pending space are ignored. Vector v's pending bit reads as bit v mod 32 of pending word v/32 (byte offset 4*(v/32)).
- R10: A release decrements the vector's use count and does nothing at zero. When the count reaches zero, the vector's pending bit is cleared.
- R11: An accepted control write whose new enable bit is 1 raises intx_deassert_o for exactly the next cycle. A control write with enable 0 gives no pulse.
- R12: A message is held on msg_addr_o/msg_data_o, unchanged, until msg_ready_i. While a message is held, ntf_ready_o is low, so a notify is back-pressured rather than lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_space_i | input | 2 | 0 = table, 1 = pending array, 2 = control |
| reg_addr_i | input | VW+4 | Byte offset within the selected space |
| reg_wdata_i | input | 32 | Write data |
| reg_gnt_o | output | 1 | Request accepted this cycle |
| reg_rdata_o | output | 32 | Read data for reg_space_i/reg_addr_i (combinational) |
| ntf_valid_i | input | 1 | Notify request |
| ntf_vec_i | input | VW | Vector to notify |
| ntf_ready_o | output | 1 | Notify accepted when high together with valid |
| use_valid_i | input | 1 | Increment a vector's use count |
| use_vec_i | input | VW | Vector to claim |
| rel_valid_i | input | 1 | Decrement a vector's use count |
| rel_vec_i | input | VW | Vector to release |
| msg_valid_o | output | 1 | Outbound message valid |
| msg_ready_i | input | 1 | Outbound message taken |
| msg_addr_o | output | 64 | Message address |
| msg_data_o | output | 32 | Message data |
| intx_deassert_o | output | 1 | One-cycle legacy interrupt deassert pulse |

## Verification
The assertions take for granted that the message sink obeys the valid/ready rule and that ntf_vec_i, use_vec_i and rel_vec_i stay below NUM_VEC. They also assume register and notify requests are held until granted. The stimulus keeps within these limits. Each bench task drives one request and holds it until reg_gnt_o or ntf_ready_o has been sampled high before an edge. msg_ready_i is raised only while a message is offered, and only vectors 0 to 7 of the 8-vector build are addressed. Use and release pulses last one cycle and never coincide with a release on the same vector.

// File: rtl/msix_pkg.sv
package msix_pkg;
  typedef enum logic [1:0] {
    SP_TABLE = 2'd0,
    SP_PEND  = 2'd1,
    SP_CTRL  = 2'd2
  } space_e;

  localparam int CtlEnBit   = 0;
  localparam int CtlMallBit = 1;
  localparam int CtlSizeLsb = 16;
  localparam int CtlSizeW   = 11;

  localparam logic [1:0] WordAddrLo = 2'd0;
  localparam logic [1:0] WordAddrHi = 2'd1;
  localparam logic [1:0] WordData   = 2'd2;
  localparam logic [1:0] WordVctl   = 2'd3;

  // pending array is sized in 64-bit multiples, read as 32-bit words
  function automatic int pend_words(input int n);
    return ((n + 63) / 64) * 2;
  endfunction
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [VW-1:0]      wr_vec_i,
  input  logic [1:0]         wr_word_i,
  input  logic [31:0]        wr_data_i,
  input  logic [VW-1:0]      rd_vec_i,
  input  logic [1:0]         rd_word_i,
  output logic [31:0]        rd_data_o,
  input  logic [VW-1:0]      msg_vec_i,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o,
  output logic [NUM_VEC-1:0] mask_o
);
  logic [63:0] addr_q [NUM_VEC];
  logic [31:0] data_q [NUM_VEC];
  logic        mask_q [NUM_VEC];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
    logic hit;
    assign hit = wr_en_i && (wr_vec_i == VW'(v));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[v] <= '0;
        data_q[v] <= '0;
        mask_q[v] <= 1'b1;
      end else if (hit) begin
        unique case (wr_word_i)
          WordAddrLo: addr_q[v][31:0]  <= wr_data_i;
          WordAddrHi: addr_q[v][63:32] <= wr_data_i;
          WordData:   data_q[v]        <= wr_data_i;
          default:    mask_q[v]        <= wr_data_i[0];
        endcase
      end
    end
    assign mask_o[v] = mask_q[v];
  end

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_vec_i) < NUM_VEC) begin
      unique case (rd_word_i)
        WordAddrLo: rd_data_o = addr_q[rd_vec_i][31:0];
        WordAddrHi: rd_data_o = addr_q[rd_vec_i][63:32];
        WordData:   rd_data_o = data_q[rd_vec_i];
        default:    rd_data_o = {31'b0, mask_q[rd_vec_i]};
      endcase
    end
  end

  always_comb begin
    msg_addr_o = '0;
    msg_data_o = '0;
    if (int'(msg_vec_i) < NUM_VEC) begin
      msg_addr_o = addr_q[msg_vec_i];
      msg_data_o = data_q[msg_vec_i];
    end
  end
endmodule

// File: rtl/msix_pend_use.sv
module msix_pend_use #(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 4,
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               use_valid_i,
  input  logic [VW-1:0]      use_vec_i,
  input  logic               rel_valid_i,
  input  logic [VW-1:0]      rel_vec_i,
  input  logic               set_en_i,
  input  logic [VW-1:0]      set_vec_i,
  input  logic               clr_en_i,
  input  logic [VW-1:0]      clr_vec_i,
  output logic [NUM_VEC-1:0] pend_o,
  output logic [NUM_VEC-1:0] used_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] cnt_q  [NUM_VEC];
  logic             pend_q [NUM_VEC];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic inc, dec, to_zero, clr, set;
    assign inc     = use_valid_i && (use_vec_i == VW'(v)) && (cnt_q[v] != CntMax);
    assign dec     = rel_valid_i && (rel_vec_i == VW'(v)) && (cnt_q[v] != '0);
    assign to_zero = dec && !inc && (cnt_q[v] == CNT_W'(1));
    assign clr     = to_zero || (clr_en_i && (clr_vec_i == VW'(v)));
    assign set     = set_en_i && (set_vec_i == VW'(v));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[v]  <= '0;
        pend_q[v] <= 1'b0;
      end else begin
        if (inc && !dec)      cnt_q[v] <= cnt_q[v] + CNT_W'(1);
        else if (dec && !inc) cnt_q[v] <= cnt_q[v] - CNT_W'(1);
        if (clr)      pend_q[v] <= 1'b0;
        else if (set) pend_q[v] <= 1'b1;
      end
    end

    assign pend_o[v] = pend_q[v];
    assign used_o[v] = (cnt_q[v] != '0);
  end

  // a pending vector is always a claimed vector
  p_pend_used_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & ~used_o) == '0);
endmodule

// File: rtl/msix_sweep.sv
module msix_sweep #(
  parameter int NUM_VEC = 8,
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          step_i,
  output logic          busy_o,
  output logic [VW-1:0] idx_o
);
  logic          busy_q;
  logic [VW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q && step_i) begin
      if (idx_q == VW'(NUM_VEC - 1)) busy_q <= 1'b0;
      else                           idx_q  <= idx_q + VW'(1);
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;

  p_idx_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (int'(idx_q) < NUM_VEC));
endmodule

// File: rtl/msix_msg_out.sv
module msix_msg_out (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [63:0] addr_i,
  input  logic [31:0] data_i,
  output logic        valid_o,
  input  logic        ready_i,
  output logic [63:0] addr_o,
  output logic [31:0] data_o
);
  logic        valid_q;
  logic [63:0] addr_q;
  logic [31:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (load_i && !valid_q) begin
      valid_q <= 1'b1;
      addr_q  <= addr_i;
      data_q  <= data_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  p_no_overwrite_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_q);

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/msix_ctrl.sv
module msix_ctrl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 4,
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int AW = VW + 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_req_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_space_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic          reg_gnt_o,
  output logic [31:0]   reg_rdata_o,
  input  logic          ntf_valid_i,
  input  logic [VW-1:0] ntf_vec_i,
  output logic          ntf_ready_o,
  input  logic          use_valid_i,
  input  logic [VW-1:0] use_vec_i,
  input  logic          rel_valid_i,
  input  logic [VW-1:0] rel_vec_i,
  output logic          msg_valid_o,
  input  logic          msg_ready_i,
  output logic [63:0]   msg_addr_o,
  output logic [31:0]   msg_data_o,
  output logic          intx_deassert_o
);
  localparam int PW = pend_words(NUM_VEC);
  localparam int PB = PW * 32;

  logic en_q, mall_q, intx_q;
  logic func_mask, out_free;
  logic sweep_busy, sweep_start, sw_step, sw_flush;
  logic [VW-1:0] sweep_idx;
  logic [NUM_VEC-1:0] vec_mask, pend, used;
  logic wr_acc, tbl_wr, ctl_wr, tbl_vec_ok, tw_flush;
  logic [VW-1:0] tbl_vec, flush_vec, msg_vec;
  logic [1:0] tbl_word;
  logic new_en, new_fm;
  logic ntf_ok, ntf_acc, ntf_masked;
  logic flush, msg_load;
  logic [31:0] tbl_rdata;
  logic [63:0] ent_addr;
  logic [31:0] ent_data;
  logic [PB-1:0] pend_pad;
  logic [AW-3:0] pend_widx;

  assign func_mask = !en_q || mall_q;
  assign out_free  = !msg_valid_o;

  // sweep and a held message stall the register port and notify
  assign reg_gnt_o   = reg_req_i && !sweep_busy && out_free;
  assign ntf_ready_o = !sweep_busy && out_free && !reg_req_i;

  assign wr_acc     = reg_gnt_o && reg_we_i;
  assign tbl_vec    = reg_addr_i[AW-1:4];
  assign tbl_word   = reg_addr_i[3:2];
  assign tbl_vec_ok = int'(tbl_vec) < NUM_VEC;
  assign tbl_wr     = wr_acc && (space_e'(reg_space_i) == SP_TABLE) && tbl_vec_ok;
  assign ctl_wr     = wr_acc && (space_e'(reg_space_i) == SP_CTRL);

  assign new_en      = reg_wdata_i[CtlEnBit];
  assign new_fm      = !new_en || reg_wdata_i[CtlMallBit];
  assign sweep_start = ctl_wr && new_en && func_mask && !new_fm;

  assign ntf_ok     = int'(ntf_vec_i) < NUM_VEC;
  assign ntf_acc    = ntf_valid_i && ntf_ready_o && ntf_ok && used[ntf_vec_i];
  assign ntf_masked = func_mask || vec_mask[ntf_vec_i];

  // per-entry unmask of a pending vector
  assign tw_flush = tbl_wr && (tbl_word == WordVctl) && !func_mask
                    && vec_mask[tbl_vec] && !reg_wdata_i[0] && pend[tbl_vec];

  assign sw_step  = sweep_busy && out_free;
  assign sw_flush = sw_step && pend[sweep_idx] && !vec_mask[sweep_idx];

  assign flush     = tw_flush || sw_flush;
  assign flush_vec = sweep_busy ? sweep_idx : tbl_vec;
  assign msg_vec   = flush ? flush_vec : ntf_vec_i;
  assign msg_load  = (flush && used[flush_vec]) || (ntf_acc && !ntf_masked);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mall_q <= 1'b0;
      intx_q <= 1'b0;
    end else begin
      intx_q <= ctl_wr && new_en;
      if (ctl_wr) begin
        en_q   <= new_en;
        mall_q <= reg_wdata_i[CtlMallBit];
      end
    end
  end
  assign intx_deassert_o = intx_q;

  msix_vec_table #(.NUM_VEC(NUM_VEC)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (tbl_wr),
    .wr_vec_i   (tbl_vec),
    .wr_word_i  (tbl_word),
    .wr_data_i  (reg_wdata_i),
    .rd_vec_i   (tbl_vec),
    .rd_word_i  (tbl_word),
    .rd_data_o  (tbl_rdata),
    .msg_vec_i  (msg_vec),
    .msg_addr_o (ent_addr),
    .msg_data_o (ent_data),
    .mask_o     (vec_mask)
  );

  msix_pend_use #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .use_valid_i (use_valid_i),
    .use_vec_i   (use_vec_i),
    .rel_valid_i (rel_valid_i),
    .rel_vec_i   (rel_vec_i),
    .set_en_i    (ntf_acc && ntf_masked),
    .set_vec_i   (ntf_vec_i),
    .clr_en_i    (flush),
    .clr_vec_i   (flush_vec),
    .pend_o      (pend),
    .used_o      (used)
  );

  msix_sweep #(.NUM_VEC(NUM_VEC)) u_sweep (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sweep_start),
    .step_i  (out_free),
    .busy_o  (sweep_busy),
    .idx_o   (sweep_idx)
  );

  msix_msg_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (msg_load),
    .addr_i  (ent_addr),
    .data_i  (ent_data),
    .valid_o (msg_valid_o),
    .ready_i (msg_ready_i),
    .addr_o  (msg_addr_o),
    .data_o  (msg_data_o)
  );

  assign pend_pad  = PB'(pend);
  assign pend_widx = reg_addr_i[AW-1:2];

  always_comb begin
    reg_rdata_o = '0;
    unique case (space_e'(reg_space_i))
      SP_TABLE: reg_rdata_o = tbl_rdata;
      SP_PEND: begin
        for (int w = 0; w < PW; w++) begin
          if (int'(pend_widx) == w) reg_rdata_o = pend_pad[w*32 +: 32];
        end
      end
      SP_CTRL: begin
        reg_rdata_o[CtlEnBit]                  = en_q;
        reg_rdata_o[CtlMallBit]                = mall_q;
        reg_rdata_o[CtlSizeLsb +: CtlSizeW]    = CtlSizeW'(NUM_VEC - 1);
      end
      default: reg_rdata_o = '0;
    endcase
  end

  p_sweep_unmasked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_busy |-> !func_mask);

  p_masked_parks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ntf_acc && ntf_masked) |=> !msg_valid_o);

  p_unmasked_sends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ntf_acc && !ntf_masked) |=> msg_valid_o);
endmodule

// File: tb/tb_msix_ctrl.sv
`timescale 1ns/1ps
module tb_msix_ctrl;
  import msix_pkg::*;

  localparam int N  = 8;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic          reg_req = 0, reg_we = 0;
  logic [1:0]    reg_space = 0;
  logic [AW-1:0] reg_addr = 0;
  logic [31:0]   reg_wdata = 0;
  logic          reg_gnt_o;
  logic [31:0]   reg_rdata_o;
  logic          ntf_valid = 0;
  logic [2:0]    ntf_vec = 0;
  logic          ntf_ready_o;
  logic          use_valid = 0, rel_valid = 0;
  logic [2:0]    use_vec = 0, rel_vec = 0;
  logic          msg_valid_o;
  logic          msg_ready = 0;
  logic [63:0]   msg_addr_o;
  logic [31:0]   msg_data_o;
  logic          intx_o;

  msix_ctrl #(.NUM_VEC(N), .CNT_W(4)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_space_i(reg_space),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_gnt_o(reg_gnt_o), .reg_rdata_o(reg_rdata_o),
    .ntf_valid_i(ntf_valid), .ntf_vec_i(ntf_vec), .ntf_ready_o(ntf_ready_o),
    .use_valid_i(use_valid), .use_vec_i(use_vec),
    .rel_valid_i(rel_valid), .rel_vec_i(rel_vec),
    .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready),
    .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o),
    .intx_deassert_o(intx_o)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] v_addr(input int v);
    return 64'hFEE0_0000_0000_1000 + 64'(v) * 64'h100;
  endfunction
  function automatic logic [31:0] v_data(input int v);
    return 32'h0000_4000 + 32'(v);
  endfunction

  task automatic reg_write(input logic [1:0] sp, input int addr, input logic [31:0] d);
    logic g;
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_space = sp; reg_addr = addr[AW-1:0]; reg_wdata = d;
    forever begin
      #1 g = reg_gnt_o;
      @(posedge clk);
      if (g) break;
      @(negedge clk);
    end
    #1 reg_req = 0; reg_we = 0;
  endtask

  task automatic reg_read(input logic [1:0] sp, input int addr, output logic [31:0] d);
    @(negedge clk);
    reg_space = sp; reg_addr = addr[AW-1:0]; reg_we = 0;
    #1 d = reg_rdata_o;
  endtask

  task automatic tbl_wr(input int v, input int w, input logic [31:0] d);
    reg_write(2'd0, v * 16 + w * 4, d);
  endtask

  task automatic rd_pend(output logic [31:0] d);
    reg_read(2'd1, 0, d);
  endtask

  task automatic notify(input int v);
    logic r;
    @(negedge clk);
    ntf_valid = 1; ntf_vec = v[2:0];
    forever begin
      #1 r = ntf_ready_o;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    #1 ntf_valid = 0;
  endtask

  task automatic claim(input int v);
    @(negedge clk); use_valid = 1; use_vec = v[2:0];
    @(posedge clk); #1 use_valid = 0;
  endtask

  task automatic release_vec(input int v);
    @(negedge clk); rel_valid = 1; rel_vec = v[2:0];
    @(posedge clk); #1 rel_valid = 0;
  endtask

  task automatic expect_msg(input string tag, input int v);
    int k;
    k = 0;
    @(negedge clk);
    while (!msg_valid_o && k < 20) begin @(negedge clk); k++; end
    chk_eq({tag, " valid"}, 64'(msg_valid_o), 64'd1);
    chk_eq({tag, " addr"}, msg_addr_o, v_addr(v));
    chk_eq({tag, " data"}, 64'(msg_data_o), 64'(v_data(v)));
    msg_ready = 1;
    @(posedge clk); #1 msg_ready = 0;
  endtask

  task automatic expect_no_msg(input string tag);
    logic seen;
    seen = 0;
    repeat (6) begin @(negedge clk); seen |= msg_valid_o; end
    chk_eq(tag, 64'(seen), 64'd0);
  endtask

  task automatic t_reset(input string tag);
    logic [31:0] d;
    reg_read(2'd2, 0, d);  chk_eq({tag, " R1 ctrl"}, 64'(d), 64'h0007_0000);
    reg_read(2'd0, 5*16+0, d); chk_eq({tag, " R1 addr lo"}, 64'(d), 0);
    reg_read(2'd0, 5*16+4, d); chk_eq({tag, " R1 addr hi"}, 64'(d), 0);
    reg_read(2'd0, 2*16+8, d); chk_eq({tag, " R1 data"}, 64'(d), 0);
    reg_read(2'd0, 5*16+12, d); chk_eq({tag, " R1 vctl masked"}, 64'(d), 1);
    rd_pend(d); chk_eq({tag, " R1 pending"}, 64'(d), 0);
    chk_eq({tag, " R1 no msg"}, 64'(msg_valid_o), 0);
    chk_eq({tag, " R1 intx"}, 64'(intx_o), 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    tbl_wr(2, 0, 32'h1111_2222); tbl_wr(2, 1, 32'h3333_4444);
    tbl_wr(2, 2, 32'h5555_6666); tbl_wr(2, 3, 32'hFFFF_FFFF);
    reg_read(2'd0, 32, d); chk_eq("R2 word0", 64'(d), 64'h1111_2222);
    reg_read(2'd0, 36, d); chk_eq("R2 word1", 64'(d), 64'h3333_4444);
    reg_read(2'd0, 40, d); chk_eq("R2 word2", 64'(d), 64'h5555_6666);
    reg_read(2'd0, 44, d); chk_eq("R2 word3 mask only", 64'(d), 1);
    tbl_wr(2, 3, 32'h0000_0002);
    reg_read(2'd0, 44, d); chk_eq("R2 word3 bit1 dropped", 64'(d), 0);
    for (int v = 0; v < N; v++) begin
      tbl_wr(v, 0, v_addr(v)[31:0]);
      tbl_wr(v, 1, v_addr(v)[63:32]);
      tbl_wr(v, 2, v_data(v));
      tbl_wr(v, 3, 32'h1);
    end
    reg_read(2'd0, 7*16+4, d); chk_eq("R2 vec7 addr hi", 64'(d), 64'(v_addr(7)[63:32]));
  endtask

  task automatic t_size();
    logic [31:0] d;
    reg_write(2'd2, 0, 32'hFFFF_0000);
    chk_eq("R11 no pulse when enable 0", 64'(intx_o), 0);
    reg_read(2'd2, 0, d); chk_eq("R3 size read-only", 64'(d), 64'h0007_0000);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    reg_write(2'd2, 0, 32'h1);
    chk_eq("R11 pulse high", 64'(intx_o), 1);
    @(posedge clk); #1;
    chk_eq("R11 pulse one cycle", 64'(intx_o), 0);
    reg_read(2'd2, 0, d); chk_eq("R3 ctrl enabled", 64'(d), 64'h0007_0001);
  endtask

  task automatic t_drop();
    logic [31:0] d;
    tbl_wr(1, 3, 32'h0);
    notify(1);
    expect_no_msg("R4 unused vector dropped");
    rd_pend(d); chk_eq("R4 no pending", 64'(d), 0);
  endtask

  task automatic t_send();
    claim(1);
    notify(1);
    expect_msg("R6 send vec1", 1);
  endtask

  task automatic t_masked();
    logic [31:0] d;
    claim(2);
    notify(2);
    expect_no_msg("R5 masked no msg");
    rd_pend(d); chk_eq("R5 pending bit2", 64'(d), 64'h4);
  endtask

  task automatic t_unmask();
    logic [31:0] d;
    tbl_wr(2, 3, 32'h0);
    expect_msg("R7 unmask flush vec2", 2);
    rd_pend(d); chk_eq("R7 pending cleared", 64'(d), 0);
    tbl_wr(3, 3, 32'h0);
    expect_no_msg("R7 unmask idle vec3");
  endtask

  task automatic t_pend_ro();
    logic [31:0] d;
    claim(4);
    notify(4);
    rd_pend(d); chk_eq("R9 bit4 set", 64'(d), 64'h10);
    reg_write(2'd1, 0, 32'h0);
    rd_pend(d); chk_eq("R9 write 0 ignored", 64'(d), 64'h10);
    reg_write(2'd1, 0, 32'hFFFF_FFFF);
    rd_pend(d); chk_eq("R9 write 1s ignored", 64'(d), 64'h10);
    reg_read(2'd1, 4, d); chk_eq("R9 word1 empty", 64'(d), 0);
  endtask

  task automatic t_sweep();
    logic [31:0] d;
    reg_write(2'd2, 0, 32'h3);
    chk_eq("R11 pulse with mask-all", 64'(intx_o), 1);
    claim(0); claim(5); claim(6);
    tbl_wr(0, 3, 32'h0); tbl_wr(5, 3, 32'h0); tbl_wr(6, 3, 32'h0);
    expect_no_msg("R8 function masked no flush");
    notify(6); notify(0); notify(5);
    rd_pend(d); chk_eq("R8 parked", 64'(d), 64'h71);
    reg_write(2'd2, 0, 32'h1);
    chk_eq("R8 notify stalled", 64'(ntf_ready_o), 0);
    expect_msg("R8 sweep first vec0", 0);
    expect_msg("R8 sweep second vec5", 5);
    expect_msg("R8 sweep third vec6", 6);
    expect_no_msg("R8 sweep done");
    rd_pend(d); chk_eq("R8 masked vec4 kept", 64'(d), 64'h10);
  endtask

  task automatic t_backpressure();
    logic held_ok;
    claim(3);
    notify(3);
    @(negedge clk);
    ntf_valid = 1; ntf_vec = 3'd1;
    held_ok = 1;
    repeat (4) begin
      @(negedge clk); #1;
      if (ntf_ready_o || !msg_valid_o || msg_addr_o !== v_addr(3)) held_ok = 0;
    end
    chk_eq("R12 held and back-pressured", 64'(held_ok), 1);
    expect_msg("R12 held vec3", 3);
    @(negedge clk); #1;
    chk_eq("R12 ready after take", 64'(ntf_ready_o), 1);
    @(posedge clk); #1 ntf_valid = 0;
    expect_msg("R12 stalled notify not lost", 1);
  endtask

  task automatic t_release();
    logic [31:0] d;
    release_vec(4);
    rd_pend(d); chk_eq("R10 zero clears pending", 64'(d), 0);
    release_vec(4);
    notify(4);
    expect_no_msg("R10 released vec dropped");
    rd_pend(d); chk_eq("R10 still clear", 64'(d), 0);
    claim(7); claim(7);
    notify(7);
    rd_pend(d); chk_eq("R10 vec7 parked", 64'(d), 64'h80);
    release_vec(7);
    rd_pend(d); chk_eq("R10 count 1 keeps pending", 64'(d), 64'h80);
    release_vec(7);
    rd_pend(d); chk_eq("R10 count 0 clears", 64'(d), 0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    reg_write(2'd2, 0, 32'h0);
    chk_eq("R11 disable no pulse", 64'(intx_o), 0);
    notify(1);
    expect_no_msg("R5 function masked no msg");
    rd_pend(d); chk_eq("R5 function masked parks", 64'(d), 64'h2);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    t_reset("initial");
    t_layout();
    t_size();
    t_enable();
    t_drop();
    t_send();
    t_masked();
    t_unmask();
    t_pend_ro();
    t_sweep();
    t_backpressure();
    t_release();
    t_disable();
    @(negedge clk) rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    t_reset("second");
    finish_run();
  end
endmodule